// File: doc/BRIEF.md
# Core Idle-Mode Power Sequencer

This block sits beside one processor core and takes it through a low-power episode each time the core signals wait-for-interrupt. A two-bit mode register picks one of four sequences. In light standby the core clock is gated and the cache hierarchy may be parked. In retention the supply is also lowered to a keep-alive level. In private power-down only this core's supply is cut and the core is held in reset. Full collapse adds a handshake with the system power manager. Every sequence ends when a wake-up interrupt arrives. The block then undoes its steps in reverse order and lets the core run again.

Handshakes with the cache hierarchy and with the system power manager are level request/acknowledge pairs. Both are used only when the all-cores-idle input is high at the moment the core goes idle. After any sequence finishes, the mode register falls back to light standby. The exception is a new mode written while the sequence was running. That write is held back and takes effect when the sequence ends. An interrupt that arrives while an entry handshake is still open is latched. It turns the entry around through the matching release steps.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the clock gate is off, the supply is on, core reset is low, both requests are low and the mode register reads 0. Mode encoding: 0 light standby, 1 retention, 2 private power-down, 3 full collapse.
- R2: A wait-for-interrupt pulse gates the core clock. The clock stays gated until the cycle after the last restore step. It is gated whenever the supply is off or the voltage-reduce request is high.
- R3: In light standby the cache-standby request is raised together with the clock gate only if all-cores-idle is high at the wait-for-interrupt. After the interrupt the request is dropped, and the clock is ungated only once the acknowledge has gone low.
- R4: In retention the voltage-reduce request rises with the clock gate and falls on the interrupt, before the clock is ungated. The supply is never cut.
- R5: In private power-down the supply is cut and core reset is raised at entry. After the interrupt the supply is restored. Reset stays high for at least max(settle, 4) cycles of restored supply before it is released, and for exactly that many when no handshake is open. No cache or system request is ever raised in this mode.
- R6: In full collapse with all cores idle, the steps run in this order: cache request, system request, supply cut with reset, interrupt, supply restore, settle, system release, cache release, reset release. Without all cores idle the mode behaves as R5.
- R7: A request stays high until its acknowledge is seen, and no later step starts before it. After a request is dropped, the next step waits for the acknowledge to go low.
- R8: After any sequence completes with no write made during it, the mode register reads 0.
- R9: A mode write made while a sequence runs does not change the mode register until the sequence ends. At the end the written value is loaded instead of 0, and this holds even for a write in the final cycle.
- R10: An interrupt that arrives while an entry handshake is open is latched. After that acknowledge, the block releases the requests already granted, in reverse order. It never cuts the supply and then resumes.
- R11: A mode write while the core runs updates the mode register on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Core entered wait-for-interrupt (pulse) |
| irq_i | input | 1 | Wake-up interrupt |
| all_idle_i | input | 1 | All cores idle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode to write |
| cfg_settle_i | input | SETTLE_W | Supply settle count to write |
| mode_o | output | 2 | Current mode register |
| clk_gate_o | output | 1 | Core clock gate (1 = gated) |
| vret_req_o | output | 1 | Voltage-reduce request |
| supply_on_o | output | 1 | Core supply switch (1 = on) |
| core_rst_o | output | 1 | Core reset (1 = held) |
| cache_req_o | output | 1 | Cache-standby request |
| cache_ack_i | input | 1 | Cache-standby acknowledge |
| pmgr_req_o | output | 1 | System power-manager request |
| pmgr_ack_i | input | 1 | System power-manager acknowledge |

## Verification
Two functions can meet in the last cycle of a sequence: the fall-back of the mode register to standby and a software mode write. The bench watches for core reset falling at the end of a private power-down. It then places the write exactly in the following resume cycle and expects the written mode, not 0. The second meeting point is an interrupt landing while an entry acknowledge is still pending. The bench pulses the interrupt inside each entry handshake window and judges the outcome by the full order of output changes, which must show the supply never cut.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef enum logic [1:0] {
    M_STBY = 2'd0,
    M_RET  = 2'd1,
    M_SPC  = 2'd2,
    M_COLL = 2'd3
  } lpm_mode_e;

  typedef enum logic [3:0] {
    S_RUN, S_CENT, S_PENT, S_WAIT, S_SETTLE, S_PEXIT, S_CEXIT, S_DONE
  } seq_state_e;

  // cycles of restored supply before reset may drop
  function automatic int unsigned settle_len(int unsigned cfg, int unsigned rmin);
    return (cfg < rmin) ? rmin : cfg;
  endfunction

endpackage

// File: rtl/idle_seq_cfg.sv
module idle_seq_cfg
  import idle_seq_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          mode_w_i,
  input  logic [SETTLE_W-1:0] settle_w_i,
  input  logic                busy_i,
  input  logic                done_i,
  output lpm_mode_e           mode_o,
  output logic [SETTLE_W-1:0] settle_o
);
  lpm_mode_e mode_q, pend_q;
  logic      pend_v_q;
  logic [SETTLE_W-1:0] settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_STBY;
      pend_q   <= M_STBY;
      pend_v_q <= 1'b0;
      settle_q <= '0;
    end else begin
      if (we_i) settle_q <= settle_w_i;
      if (done_i) begin
        // a write in the last cycle beats the fall-back
        mode_q   <= we_i ? lpm_mode_e'(mode_w_i) : (pend_v_q ? pend_q : M_STBY);
        pend_v_q <= 1'b0;
      end else if (we_i) begin
        if (busy_i) begin
          pend_q   <= lpm_mode_e'(mode_w_i);
          pend_v_q <= 1'b1;
        end else begin
          mode_q <= lpm_mode_e'(mode_w_i);
        end
      end
    end
  end

  assign mode_o   = mode_q;
  assign settle_o = settle_q;
endmodule

// File: rtl/idle_seq_timer.sv
module idle_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wfi_i,
  input  logic      irq_i,
  input  logic      all_idle_i,
  input  lpm_mode_e mode_i,
  input  logic      cache_ack_i,
  input  logic      pmgr_ack_i,
  input  logic      tmr_done_i,
  output logic      tmr_load_o,
  output logic      busy_o,
  output logic      done_o,
  output lpm_mode_e act_mode_o,
  output logic      clk_gate_o,
  output logic      vret_o,
  output logic      supply_off_o,
  output logic      core_rst_o,
  output logic      cache_req_o,
  output logic      pmgr_req_o
);
  seq_state_e state_q;
  lpm_mode_e  act_q;
  logic gate_q, vret_q, off_q, rst_q, creq_q, preq_q, irq_lat_q;
  logic wake;

  assign wake = irq_lat_q | irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;   act_q  <= M_STBY;
      gate_q  <= 1'b0;    vret_q <= 1'b0;  off_q  <= 1'b0;
      rst_q   <= 1'b0;    creq_q <= 1'b0;  preq_q <= 1'b0;
      irq_lat_q <= 1'b0;
    end else begin
      if (state_q != S_RUN) irq_lat_q <= irq_lat_q | irq_i;
      case (state_q)
        S_RUN: if (wfi_i) begin
          gate_q    <= 1'b1;
          act_q     <= mode_i;
          irq_lat_q <= irq_i;
          case (mode_i)
            M_RET: begin vret_q <= 1'b1; state_q <= S_WAIT; end
            M_SPC: begin off_q <= 1'b1; rst_q <= 1'b1; state_q <= S_WAIT; end
            default: begin // standby and collapse consult the other cores
              if (all_idle_i) begin
                creq_q <= 1'b1; state_q <= S_CENT;
              end else if (mode_i == M_COLL) begin
                off_q <= 1'b1; rst_q <= 1'b1; state_q <= S_WAIT;
              end else begin
                state_q <= S_WAIT;
              end
            end
          endcase
        end
        S_CENT: if (cache_ack_i) begin
          if (wake) begin
            creq_q <= 1'b0; state_q <= S_CEXIT;
          end else if (act_q == M_COLL) begin
            preq_q <= 1'b1; state_q <= S_PENT;
          end else begin
            state_q <= S_WAIT;
          end
        end
        S_PENT: if (pmgr_ack_i) begin
          if (wake) begin
            preq_q <= 1'b0; state_q <= S_PEXIT;
          end else begin
            off_q <= 1'b1; rst_q <= 1'b1; state_q <= S_WAIT;
          end
        end
        S_WAIT: if (wake) begin
          if (vret_q) begin
            vret_q <= 1'b0; state_q <= S_DONE;
          end else if (off_q) begin
            off_q <= 1'b0; state_q <= S_SETTLE;
          end else if (creq_q) begin
            creq_q <= 1'b0; state_q <= S_CEXIT;
          end else begin
            state_q <= S_DONE;
          end
        end
        S_SETTLE: if (tmr_done_i) begin
          if (preq_q) begin
            preq_q <= 1'b0; state_q <= S_PEXIT;
          end else if (creq_q) begin
            creq_q <= 1'b0; state_q <= S_CEXIT;
          end else begin
            rst_q <= 1'b0; state_q <= S_DONE;
          end
        end
        S_PEXIT: if (!pmgr_ack_i) begin
          if (creq_q) begin
            creq_q <= 1'b0; state_q <= S_CEXIT;
          end else begin
            rst_q <= 1'b0; state_q <= S_DONE;
          end
        end
        S_CEXIT: if (!cache_ack_i) begin
          rst_q <= 1'b0; state_q <= S_DONE;
        end
        S_DONE: begin
          gate_q <= 1'b0; irq_lat_q <= 1'b0; state_q <= S_RUN;
        end
        default: state_q <= S_RUN;
      endcase
    end
  end

  assign tmr_load_o   = (state_q == S_WAIT) && wake && !vret_q && off_q;
  assign busy_o       = (state_q != S_RUN);
  assign done_o       = (state_q == S_DONE);
  assign act_mode_o   = act_q;
  assign clk_gate_o   = gate_q;
  assign vret_o       = vret_q;
  assign supply_off_o = off_q;
  assign core_rst_o   = rst_q;
  assign cache_req_o  = creq_q;
  assign pmgr_req_o   = preq_q;
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import idle_seq_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int RST_MIN  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wfi_i,
  input  logic                irq_i,
  input  logic                all_idle_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_mode_i,
  input  logic [SETTLE_W-1:0] cfg_settle_i,
  output logic [1:0]          mode_o,
  output logic                clk_gate_o,
  output logic                vret_req_o,
  output logic                supply_on_o,
  output logic                core_rst_o,
  output logic                cache_req_o,
  input  logic                cache_ack_i,
  output logic                pmgr_req_o,
  input  logic                pmgr_ack_i
);
  // named internal events, also seen by the checker
  lpm_mode_e           mode_cur;
  lpm_mode_e           act_mode;
  logic [SETTLE_W-1:0] settle_cfg;
  logic [SETTLE_W-1:0] settle_cyc;
  logic seq_busy, seq_done, cfg_busy, tmr_load, tmr_done, supply_off;

  assign cfg_busy   = seq_busy | wfi_i;
  assign settle_cyc = SETTLE_W'(settle_len(int'(settle_cfg), RST_MIN));

  idle_seq_cfg #(.SETTLE_W(SETTLE_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .mode_w_i(cfg_mode_i),
    .settle_w_i(cfg_settle_i), .busy_i(cfg_busy), .done_i(seq_done),
    .mode_o(mode_cur), .settle_o(settle_cfg)
  );

  idle_seq_timer #(.W(SETTLE_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .len_i(settle_cyc),
    .done_o(tmr_done)
  );

  idle_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wfi_i(wfi_i), .irq_i(irq_i),
    .all_idle_i(all_idle_i), .mode_i(mode_cur), .cache_ack_i(cache_ack_i),
    .pmgr_ack_i(pmgr_ack_i), .tmr_done_i(tmr_done), .tmr_load_o(tmr_load),
    .busy_o(seq_busy), .done_o(seq_done), .act_mode_o(act_mode),
    .clk_gate_o(clk_gate_o), .vret_o(vret_req_o), .supply_off_o(supply_off),
    .core_rst_o(core_rst_o), .cache_req_o(cache_req_o), .pmgr_req_o(pmgr_req_o)
  );

  assign mode_o      = mode_cur;
  assign supply_on_o = !supply_off;
endmodule

// File: rtl/idle_seq_chk.sv
module idle_seq_chk
  import idle_seq_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int RST_MIN  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clk_gate_o,
  input logic                vret_req_o,
  input logic                supply_on_o,
  input logic                core_rst_o,
  input logic                cache_req_o,
  input logic                cache_ack_i,
  input logic                pmgr_req_o,
  input logic                pmgr_ack_i,
  input logic                seq_busy,
  input lpm_mode_e           act_mode,
  input logic [SETTLE_W-1:0] settle_cfg
);
  logic [SETTLE_W:0] on_cnt;
  logic [SETTLE_W:0] need;

  assign need = (SETTLE_W+1)'(settle_len(int'(settle_cfg), RST_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_cnt <= '0;
    else if (supply_on_o && core_rst_o) begin
      if (on_cnt != '1) on_cnt <= on_cnt + 1'b1;
    end else on_cnt <= '0;
  end

  a_r2_gate_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_on_o |-> clk_gate_o);
  a_r2_gate_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vret_req_o |-> clk_gate_o);
  a_r5_off_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_on_o |-> core_rst_o);
  a_r5_reset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (on_cnt >= need));
  a_r5_private: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && act_mode == M_SPC) |-> (!cache_req_o && !pmgr_req_o));
  a_r6_pmgr_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmgr_req_o |-> cache_req_o);
  a_r6_release_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (!cache_req_o && !pmgr_req_o));
  a_r7_cache_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_o && !cache_ack_i) |=> cache_req_o);
  a_r7_cache_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cache_req_o && cache_ack_i) |=> !cache_req_o);
  a_r7_pmgr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmgr_req_o && !pmgr_ack_i) |=> pmgr_req_o);
  a_r7_pmgr_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pmgr_req_o && pmgr_ack_i) |=> !pmgr_req_o);
endmodule

bind core_idle_seq idle_seq_chk #(.SETTLE_W(SETTLE_W), .RST_MIN(RST_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_gate_o(clk_gate_o), .vret_req_o(vret_req_o),
  .supply_on_o(supply_on_o), .core_rst_o(core_rst_o), .cache_req_o(cache_req_o),
  .cache_ack_i(cache_ack_i), .pmgr_req_o(pmgr_req_o), .pmgr_ack_i(pmgr_ack_i),
  .seq_busy(seq_busy), .act_mode(act_mode), .settle_cfg(settle_cfg)
);

// File: tb/test_core_idle_seq.sv
`timescale 1ns/1ps
module test_core_idle_seq;
  localparam int SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi = 0, irq = 0, all_idle = 0, we = 0;
  logic [1:0] wmode = 0;
  logic [SW-1:0] wsettle = 0;
  logic [1:0] mode_o;
  logic gate, vret, sup_on, crst, creq, cack, preq, pack;

  always #2.5 clk = ~clk;

  core_idle_seq #(.SETTLE_W(SW), .RST_MIN(4)) i_core_idle_seq (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .irq_i(irq), .all_idle_i(all_idle),
    .cfg_we_i(we), .cfg_mode_i(wmode), .cfg_settle_i(wsettle), .mode_o(mode_o),
    .clk_gate_o(gate), .vret_req_o(vret), .supply_on_o(sup_on), .core_rst_o(crst),
    .cache_req_o(creq), .cache_ack_i(cack), .pmgr_req_o(preq), .pmgr_ack_i(pack)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [5:0] v; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [5:0] v, string tag);
    exp_t e; e.v = v; e.tag = tag; sb.push_back(e);
  endtask

  // vector order: gate, vret, supply_on, reset, cache_req, pmgr_req
  wire [5:0] vec = {gate, vret, sup_on, crst, creq, preq};

  // acknowledge responders: follow requests three falling edges later
  logic [2:0] ch = 0, ph = 0;
  assign cack = ch[2];
  assign pack = ph[2];
  initial forever begin
    @(negedge clk);
    ch = {ch[1:0], creq};
    ph = {ph[1:0], preq};
  end

  // monitor: every change of the output vector pops one expected item
  int on_cnt = 0, last_settle = -1;
  initial begin
    logic [5:0] prev;
    exp_t e;
    @(posedge rst_n);
    @(negedge clk);
    prev = vec;
    forever begin
      @(negedge clk);
      if (vec != prev) begin
        if (sb.size() == 0) check("R7 unexpected output change", int'(vec), int'(prev));
        else begin
          e = sb.pop_front();
          check(e.tag, int'(vec), int'(e.v));
        end
      end
      if (sup_on && crst) on_cnt++;
      else begin
        if (prev[2] && !crst) last_settle = on_cnt;
        on_cnt = 0;
      end
      prev = vec;
    end
  end

  task automatic cfg(logic [1:0] m, logic [SW-1:0] s);
    @(negedge clk); we = 1; wmode = m; wsettle = s;
    @(negedge clk); we = 0;
  endtask

  task automatic push_private(string tag);
    push(6'b100100, tag); push(6'b101100, tag);
    push(6'b101000, tag); push(6'b001000, tag);
  endtask

  task automatic run_seq(bit idle, int dly, bit mid_wr, logic [1:0] mid_mode);
    all_idle = idle;
    @(negedge clk); wfi = 1;
    @(negedge clk); wfi = 0;
    if (mid_wr) begin
      logic [1:0] old = mode_o;
      @(negedge clk); we = 1; wmode = mid_mode;
      @(negedge clk); we = 0;
      check("R9 write deferred during sequence", int'(mode_o), int'(old));
    end
    repeat (dly) @(negedge clk);
    irq = 1;
    @(negedge clk); irq = 0;
    while (gate) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int exp_len(int s);
    return (s > 4) ? s : 4;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", int'(vec), 'b001000);
    check("R1 reset mode", int'(mode_o), 0);

    // light standby, not all idle
    cfg(2'd0, 8'd2);
    push(6'b101000, "R3 standby no cache"); push(6'b001000, "R2 standby resume");
    run_seq(0, 6, 0, 0);

    // light standby, all idle
    push(6'b101010, "R3 cache enter"); push(6'b101000, "R3 cache release");
    push(6'b001000, "R3 resume");
    run_seq(1, 20, 0, 0);

    // retention
    cfg(2'd1, 8'd2);
    check("R11 idle write immediate", int'(mode_o), 1);
    push(6'b111000, "R4 gate and lower"); push(6'b101000, "R4 raise");
    push(6'b001000, "R4 resume");
    run_seq(1, 8, 0, 0);
    check("R8 fall-back after retention", int'(mode_o), 0);

    // private power-down, short settle, all idle high must be ignored
    cfg(2'd2, 8'd2);
    push_private("R5 private short settle");
    run_seq(1, 5, 0, 0);
    check("R5 reset hold min 4", last_settle, exp_len(2));
    check("R8 fall-back after private", int'(mode_o), 0);

    // private power-down, long settle, write collapse mid-sequence
    cfg(2'd2, 8'd9);
    push_private("R5 private long settle");
    run_seq(0, 5, 1, 2'd3);
    check("R5 reset hold settle", last_settle, exp_len(9));
    check("R9 deferred write applied", int'(mode_o), 3);

    // full collapse, all idle
    push(6'b101010, "R6 cache req"); push(6'b101011, "R6 pmgr req");
    push(6'b100111, "R6 cut"); push(6'b101111, "R6 restore");
    push(6'b101110, "R6 pmgr release"); push(6'b101100, "R6 cache release");
    push(6'b101000, "R6 reset release"); push(6'b001000, "R6 resume");
    run_seq(1, 20, 0, 0);
    check("R8 fall-back after collapse", int'(mode_o), 0);

    // full collapse without all idle acts as private
    cfg(2'd3, 8'd3);
    push_private("R6 collapse not all idle");
    run_seq(0, 5, 0, 0);

    // interrupt during cache entry handshake
    cfg(2'd3, 8'd3);
    push(6'b101010, "R10 cache req"); push(6'b101000, "R10 cache abort");
    push(6'b001000, "R10 resume");
    run_seq(1, 0, 0, 0);

    // interrupt during system entry handshake
    cfg(2'd3, 8'd3);
    push(6'b101010, "R10 cache req"); push(6'b101011, "R10 pmgr req");
    push(6'b101010, "R10 pmgr abort"); push(6'b101000, "R10 cache abort");
    push(6'b001000, "R10 resume");
    run_seq(1, 3, 0, 0);

    // write landing in the final (resume) cycle
    cfg(2'd2, 8'd0);
    push_private("R5 private zero settle");
    all_idle = 0;
    @(negedge clk); wfi = 1;
    @(negedge clk); wfi = 0;
    repeat (5) @(negedge clk);
    irq = 1;
    @(negedge clk); irq = 0;
    while (!crst) @(negedge clk);
    while (crst) @(negedge clk);
    we = 1; wmode = 2'd1;
    @(negedge clk); we = 0;
    check("R9 last-cycle write wins", int'(mode_o), 1);
    check("R2 ungated after resume", int'(gate), 0);
    repeat (4) @(negedge clk);
    check("R5 reset hold with zero settle", last_settle, exp_len(0));

    check("R7 all expected events seen", sb.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule